// File: doc/BRIEF.md
# Textured Pixel Fetch, Filter and Depth Pipeline

This block turns a run of pixels into texture-filtered, colour-modulated, depth-tested stores. Software loads a starting texture coordinate pair (S, T) in unsigned fixed point, a starting depth, per-pixel step values for all three, a texture wrap mask, a modulation colour, a destination base address and a pixel count. It then pulses `start`. For every pixel the unit requests the four neighbouring texels through a request/response port. It addresses them by bit-interleaving the integer parts of S and T. It blends the four texels bilinearly, multiplies the result by the modulation colour, reads the stored depth at the pixel's destination, and writes colour and depth when the incoming depth is nearer.

The pixels overlap in flight. Texel requests for the next pixel go out while earlier pixels are still waiting for texels or are in the depth stage. A small in-order queue carries each pixel's fractions, depth and destination from request issue to the return of its last texel. Texel memory and block decompression sit outside the block. Texel responses must come back in request order, and the depth memory is a synchronous-read array with a single cycle of latency.

Top module: `texpipe`

## Requirements
- R1: While reset is held and when idle after it, `busy` and `done` are low and neither `tex_req_valid` nor `px_wr_en` is asserted.
- R2: Each pixel issues exactly four texel requests, in this order: (S,T), (S+1,T), (S,T+1), (S+1,T+1), where S and T are the integer coordinate parts. The texel address puts bit k of S at address bit 2k and bit k of T at address bit 2k+1. It is then ANDed with `tex_mask`. `tex_req_blk` carries the masked address shifted right by 4, and `tex_req_idx` carries its low 4 bits.
- R3: S+1 and T+1 wrap within the integer width, so 255+1 gives 0 with the default widths, and address bits cleared in `tex_mask` read as zero.
- R4: A texel packs channel c at bits [8c+7:8c]. With a 4-bit fraction f, each channel blends as lerp(a,b,f) = (a*(16-f) + b*f + 8) >> 4. The first blend is top = lerp(t00,t10,fs) and the second is bottom = lerp(t01,t11,fs). The result is lerp(top,bottom,ft), where fs and ft are the low 4 bits of S and T.
- R5: Each filtered channel a is scaled by the matching modulation channel m as (a*m + 255) >> 8, so 255 is the identity.
- R6: The stored depth is read at the pixel's destination address one cycle before the decision. Colour and depth are written only when the incoming depth is strictly less than the stored value. An equal depth is not written.
- R7: After each pixel, S, T and depth advance by their step values (wrapping modulo their widths). Pixel i goes to destination `dst_base + i`.
- R8: While `tex_req_valid` is high and `tex_req_ready` is low, the request holds with a stable address. No pixel is lost or reordered under backpressure.
- R9: After the last store, `done` pulses high for one cycle while `busy` is already low. A pixel count of zero produces `done` within three cycles and no requests.
- R10: A `start` pulse while `busy` is high is ignored and issues no extra requests.
- R11: Pixels overlap. With a ready texel port and a two-cycle response latency, N pixels finish within 4N+12 cycles of `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; ignored while busy |
| pix_count | input | PIX_W | Number of pixels in the run |
| s_start | input | INT_W+4 | Starting S coordinate, 4 fraction bits |
| t_start | input | INT_W+4 | Starting T coordinate, 4 fraction bits |
| s_step | input | INT_W+4 | S increment per pixel |
| t_step | input | INT_W+4 | T increment per pixel |
| z_start | input | DEPTH_W | Starting depth |
| z_step | input | DEPTH_W | Depth increment per pixel |
| tex_mask | input | 2*INT_W | Wrap mask on the interleaved texel address |
| mod_color | input | 32 | Modulation colour, four 8-bit channels |
| dst_base | input | ADDR_W | Destination address of the first pixel |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the run has drained |
| tex_req_valid | output | 1 | Texel request valid |
| tex_req_ready | input | 1 | Texel request accepted |
| tex_req_blk | output | 2*INT_W-4 | Block address of the texel |
| tex_req_idx | output | 4 | Texel index within the 4x4 block |
| tex_rsp_valid | input | 1 | Texel response valid, in request order |
| tex_rsp_texel | input | 32 | Returned RGBA texel |
| z_rd_en | output | 1 | Depth read strobe |
| z_rd_addr | output | ADDR_W | Depth read address |
| z_rd_data | input | DEPTH_W | Depth read data, one cycle after the strobe |
| px_wr_en | output | 1 | Colour and depth write strobe |
| px_wr_addr | output | ADDR_W | Write address |
| px_wr_color | output | 32 | Colour to store |
| px_wr_depth | output | DEPTH_W | Depth to store |

## Verification
The hazard is the depth compare and store of one pixel landing in the same cycle as the texel request issue and response collection of the pixels behind it. In that cycle the queue is both popped and pushed. Back-to-back runs provoke this, once with a texel port that is always ready and once with one that refuses every third cycle. Two scoreboards judge the outcome: one compares every accepted request address in order, and the other compares every store's address, colour and depth in order. A cycle bound on the ready run confirms that the overlap actually happens, and a final sweep of the depth array checks that no write went astray.

// File: rtl/texpipe_pkg.sv
package texpipe_pkg;
    localparam int FRAC_W  = 4;
    localparam int CH_W    = 8;
    localparam int NUM_CH  = 4;
    localparam int TEXEL_W = CH_W * NUM_CH;
    localparam int IDX_W   = 4;
    localparam int ACC_W   = CH_W + FRAC_W + 1;
    localparam int PROD_W  = 2 * CH_W;

    typedef enum logic [1:0] {
        TAP_00 = 2'd0,
        TAP_10 = 2'd1,
        TAP_01 = 2'd2,
        TAP_11 = 2'd3
    } tap_e;

    function automatic logic [CH_W-1:0] lerp_ch(input logic [CH_W-1:0] a,
                                                input logic [CH_W-1:0] b,
                                                input logic [FRAC_W-1:0] f);
        logic [ACC_W-1:0] acc;
        acc = ACC_W'(a) * (ACC_W'(1 << FRAC_W) - ACC_W'(f))
            + ACC_W'(b) * ACC_W'(f)
            + ACC_W'(1 << (FRAC_W - 1));
        return acc[FRAC_W +: CH_W];
    endfunction

    function automatic logic [CH_W-1:0] scale_ch(input logic [CH_W-1:0] a,
                                                 input logic [CH_W-1:0] m);
        logic [PROD_W-1:0] p;
        p = PROD_W'(a) * PROD_W'(m) + PROD_W'({CH_W{1'b1}});
        return p[CH_W +: CH_W];
    endfunction
endpackage

// File: rtl/texpipe_fifo.sv
module texpipe_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.mem[f_q.wr] = push_data;
            f_d.wr = (f_q.wr == PTR_W'(DEPTH - 1)) ? '0 : f_q.wr + PTR_W'(1);
        end
        if (pop) begin
            f_d.rd = (f_q.rd == PTR_W'(DEPTH - 1)) ? '0 : f_q.rd + PTR_W'(1);
        end
        f_d.cnt = f_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head  = f_q.mem[f_q.rd];
    assign empty = (f_q.cnt == '0);
    assign full  = (f_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/texpipe_addr.sv
module texpipe_addr
    import texpipe_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic [INT_W-1:0]       s_int,
    input  logic [INT_W-1:0]       t_int,
    input  tap_e                   tap,
    input  logic [2*INT_W-1:0]     mask,
    output logic [2*INT_W-IDX_W-1:0] blk,
    output logic [IDX_W-1:0]       idx
);
    localparam int MORT_W = 2 * INT_W;

    logic [INT_W-1:0]  sx, ty;
    logic [MORT_W-1:0] mort, masked;

    assign sx = s_int + INT_W'(tap[0]);
    assign ty = t_int + INT_W'(tap[1]);

    for (genvar k = 0; k < INT_W; k++) begin : g_interleave
        assign mort[2*k]   = sx[k];
        assign mort[2*k+1] = ty[k];
    end

    assign masked = mort & mask;
    assign blk    = masked[MORT_W-1:IDX_W];
    assign idx    = masked[IDX_W-1:0];
endmodule

// File: rtl/texpipe_filter.sv
module texpipe_filter
    import texpipe_pkg::*;
(
    input  logic [TEXEL_W-1:0] tex00,
    input  logic [TEXEL_W-1:0] tex10,
    input  logic [TEXEL_W-1:0] tex01,
    input  logic [TEXEL_W-1:0] tex11,
    input  logic [FRAC_W-1:0]  fs,
    input  logic [FRAC_W-1:0]  ft,
    input  logic [TEXEL_W-1:0] modc,
    output logic [TEXEL_W-1:0] color
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CH_W-1:0] top_c, bot_c, mix_c;
        assign top_c = lerp_ch(tex00[c*CH_W +: CH_W], tex10[c*CH_W +: CH_W], fs);
        assign bot_c = lerp_ch(tex01[c*CH_W +: CH_W], tex11[c*CH_W +: CH_W], fs);
        assign mix_c = lerp_ch(top_c, bot_c, ft);
        assign color[c*CH_W +: CH_W] = scale_ch(mix_c, modc[c*CH_W +: CH_W]);
    end
endmodule

// File: rtl/texpipe.sv
module texpipe
    import texpipe_pkg::*;
#(
    parameter int INT_W    = 8,
    parameter int DEPTH_W  = 16,
    parameter int ADDR_W   = 10,
    parameter int PIX_W    = 12,
    parameter int INFLIGHT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [PIX_W-1:0]            pix_count,
    input  logic [INT_W+FRAC_W-1:0]     s_start,
    input  logic [INT_W+FRAC_W-1:0]     t_start,
    input  logic [INT_W+FRAC_W-1:0]     s_step,
    input  logic [INT_W+FRAC_W-1:0]     t_step,
    input  logic [DEPTH_W-1:0]          z_start,
    input  logic [DEPTH_W-1:0]          z_step,
    input  logic [2*INT_W-1:0]          tex_mask,
    input  logic [TEXEL_W-1:0]          mod_color,
    input  logic [ADDR_W-1:0]           dst_base,
    output logic                        busy,
    output logic                        done,
    output logic                        tex_req_valid,
    input  logic                        tex_req_ready,
    output logic [2*INT_W-IDX_W-1:0]    tex_req_blk,
    output logic [IDX_W-1:0]            tex_req_idx,
    input  logic                        tex_rsp_valid,
    input  logic [TEXEL_W-1:0]          tex_rsp_texel,
    output logic                        z_rd_en,
    output logic [ADDR_W-1:0]           z_rd_addr,
    input  logic [DEPTH_W-1:0]          z_rd_data,
    output logic                        px_wr_en,
    output logic [ADDR_W-1:0]           px_wr_addr,
    output logic [TEXEL_W-1:0]          px_wr_color,
    output logic [DEPTH_W-1:0]          px_wr_depth
);
    localparam int COORD_W = INT_W + FRAC_W;
    localparam int MORT_W  = 2 * INT_W;

    typedef struct packed {
        logic [FRAC_W-1:0]  sf;
        logic [FRAC_W-1:0]  tf;
        logic [DEPTH_W-1:0] z;
        logic [ADDR_W-1:0]  addr;
    } tag_t;

    localparam int TAG_W = $bits(tag_t);

    typedef struct packed {
        logic               run;
        logic               done;
        logic [PIX_W-1:0]   rem;
        tap_e               tap;
        logic [COORD_W-1:0] s;
        logic [COORD_W-1:0] t;
        logic [DEPTH_W-1:0] z;
        logic [ADDR_W-1:0]  addr;
        logic [COORD_W-1:0] ds;
        logic [COORD_W-1:0] dt;
        logic [DEPTH_W-1:0] dz;
        logic [MORT_W-1:0]  mask;
        logic [TEXEL_W-1:0] modc;
        logic [1:0]         col_cnt;
        logic [TEXEL_W-1:0] tex0;
        logic [TEXEL_W-1:0] tex1;
        logic [TEXEL_W-1:0] tex2;
        logic               c_valid;
        logic [TEXEL_W-1:0] c_color;
        logic [DEPTH_W-1:0] c_depth;
        logic [ADDR_W-1:0]  c_addr;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    logic       issue, fire, push, pop;
    logic       q_empty, q_full;
    tag_t       push_tag, head_tag;
    logic [TAG_W-1:0] head_bits;
    logic [TEXEL_W-1:0] filt_color;

    assign push_tag.sf   = st_q.s[FRAC_W-1:0];
    assign push_tag.tf   = st_q.t[FRAC_W-1:0];
    assign push_tag.z    = st_q.z;
    assign push_tag.addr = st_q.addr;
    assign head_tag      = tag_t'(head_bits);

    texpipe_addr #(.INT_W(INT_W)) u_addr (
        .s_int (st_q.s[COORD_W-1:FRAC_W]),
        .t_int (st_q.t[COORD_W-1:FRAC_W]),
        .tap   (st_q.tap),
        .mask  (st_q.mask),
        .blk   (tex_req_blk),
        .idx   (tex_req_idx)
    );

    texpipe_fifo #(.WIDTH(TAG_W), .DEPTH(INFLIGHT)) u_tagq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_tag),
        .pop       (pop),
        .head      (head_bits),
        .empty     (q_empty),
        .full      (q_full)
    );

    texpipe_filter u_filt (
        .tex00 (st_q.tex0),
        .tex10 (st_q.tex1),
        .tex01 (st_q.tex2),
        .tex11 (tex_rsp_texel),
        .fs    (head_tag.sf),
        .ft    (head_tag.tf),
        .modc  (st_q.modc),
        .color (filt_color)
    );

    always_comb begin
        st_d  = st_q;
        issue = st_q.run && (st_q.rem != '0) && !q_full;
        fire  = issue && tex_req_ready;
        push  = 1'b0;
        pop   = 1'b0;
        st_d.done    = 1'b0;
        st_d.c_valid = 1'b0;

        if (!st_q.run) begin
            if (start) begin
                st_d.run  = 1'b1;
                st_d.rem  = pix_count;
                st_d.tap  = TAP_00;
                st_d.s    = s_start;
                st_d.t    = t_start;
                st_d.z    = z_start;
                st_d.addr = dst_base;
                st_d.ds   = s_step;
                st_d.dt   = t_step;
                st_d.dz   = z_step;
                st_d.mask = tex_mask;
                st_d.modc = mod_color;
                st_d.col_cnt = 2'd0;
            end
        end else begin
            if (fire) begin
                if (st_q.tap == TAP_11) begin
                    push      = 1'b1;
                    st_d.tap  = TAP_00;
                    st_d.s    = st_q.s + st_q.ds;
                    st_d.t    = st_q.t + st_q.dt;
                    st_d.z    = st_q.z + st_q.dz;
                    st_d.addr = st_q.addr + ADDR_W'(1);
                    st_d.rem  = st_q.rem - PIX_W'(1);
                end else begin
                    st_d.tap = tap_e'(st_q.tap + 2'd1);
                end
            end

            if (tex_rsp_valid) begin
                st_d.col_cnt = st_q.col_cnt + 2'd1;
                case (st_q.col_cnt)
                    2'd0: st_d.tex0 = tex_rsp_texel;
                    2'd1: st_d.tex1 = tex_rsp_texel;
                    2'd2: st_d.tex2 = tex_rsp_texel;
                    default: begin
                        pop          = 1'b1;
                        st_d.c_valid = 1'b1;
                        st_d.c_color = filt_color;
                        st_d.c_depth = head_tag.z;
                        st_d.c_addr  = head_tag.addr;
                    end
                endcase
            end

            if ((st_q.rem == '0) && q_empty && !st_q.c_valid && (st_q.col_cnt == 2'd0)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy          = st_q.run;
    assign done          = st_q.done;
    assign tex_req_valid = issue;
    assign z_rd_en       = pop;
    assign z_rd_addr     = head_tag.addr;
    assign px_wr_en      = st_q.c_valid && (st_q.c_depth < z_rd_data);
    assign px_wr_addr    = st_q.c_addr;
    assign px_wr_color   = st_q.c_color;
    assign px_wr_depth   = st_q.c_depth;
endmodule

// File: rtl/texpipe_chk.sv
module texpipe_chk #(
    parameter int INT_W  = 8,
    parameter int ADDR_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic                  tex_req_valid,
    input logic                  tex_req_ready,
    input logic [2*INT_W-5:0]    tex_req_blk,
    input logic [3:0]            tex_req_idx,
    input logic                  z_rd_en,
    input logic [ADDR_W-1:0]     z_rd_addr,
    input logic                  px_wr_en,
    input logic [ADDR_W-1:0]     px_wr_addr
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tex_req_valid && !px_wr_en));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tex_req_valid && !tex_req_ready) |=>
            (tex_req_valid && $stable(tex_req_blk) && $stable(tex_req_idx)));

    assert_zread_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        px_wr_en |-> ($past(z_rd_en) && (px_wr_addr == $past(z_rd_addr))));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind texpipe texpipe_chk #(.INT_W(INT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/texpipe_test.sv
`timescale 1ns/1ps
module texpipe_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [11:0] pix_count;
    logic [11:0] s_start, t_start, s_step, t_step;
    logic [15:0] z_start, z_step, tex_mask;
    logic [31:0] mod_color;
    logic [9:0]  dst_base;
    logic        busy, done;
    logic        tex_req_valid, tex_req_ready;
    logic [11:0] tex_req_blk;
    logic [3:0]  tex_req_idx;
    logic        tex_rsp_valid;
    logic [31:0] tex_rsp_texel;
    logic        z_rd_en;
    logic [9:0]  z_rd_addr;
    logic [15:0] z_rd_data;
    logic        px_wr_en;
    logic [9:0]  px_wr_addr;
    logic [31:0] px_wr_color;
    logic [15:0] px_wr_depth;

    always #2 clk = ~clk;

    texpipe uut (.*);

    int unsigned cyc = 0;
    int errors = 0;
    int checks = 0;
    bit stall_mode = 1'b0;
    string cur_label = "R1";

    logic [15:0] exp_req[$];
    logic [57:0] exp_wr[$];
    logic [31:0] rsp_q[$];
    int unsigned rsp_due[$];
    logic [15:0] zmem[0:1023];
    logic [15:0] zmodel[0:1023];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] morton(input logic [7:0] s, input logic [7:0] t);
        logic [15:0] m;
        for (int k = 0; k < 8; k++) begin
            m[2*k]   = s[k];
            m[2*k+1] = t[k];
        end
        return m;
    endfunction

    function automatic logic [31:0] texel_of(input logic [15:0] m);
        logic [7:0] lo, hi, c0, c1, c2, c3;
        lo = m[7:0];
        hi = m[15:8];
        c0 = lo * 8'd5;
        c1 = ~lo;
        c2 = hi + 8'd29;
        c3 = lo ^ hi;
        return {c3, c2, c1, c0};
    endfunction

    function automatic logic [7:0] blend(input logic [7:0] a, input logic [7:0] b, input logic [3:0] f);
        int v;
        v = (int'(a) * (16 - int'(f)) + int'(b) * int'(f) + 8) >> 4;
        return v[7:0];
    endfunction

    function automatic logic [7:0] modul(input logic [7:0] a, input logic [7:0] m);
        int v;
        v = (int'(a) * int'(m) + 255) >> 8;
        return v[7:0];
    endfunction

    // zero-latency-free synchronous depth array
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) zmem[i] <= 16'h4000;
        end else begin
            if (z_rd_en)  z_rd_data <= zmem[z_rd_addr];
            if (px_wr_en) zmem[px_wr_addr] <= px_wr_depth;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // texel responder plus request and store monitors
    always @(negedge clk) begin
        if (!rst_n) begin
            tex_rsp_valid = 1'b0;
            tex_req_ready = 1'b0;
            tex_rsp_texel = '0;
        end else begin
            if (rsp_q.size() > 0 && rsp_due[0] <= cyc) begin
                tex_rsp_valid = 1'b1;
                tex_rsp_texel = rsp_q.pop_front();
                void'(rsp_due.pop_front());
            end else begin
                tex_rsp_valid = 1'b0;
            end
            tex_req_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (tex_req_valid && tex_req_ready) begin
                if (exp_req.size() == 0) begin
                    check(1'b0, "R10 R2", "unexpected texel request", {48'd0, tex_req_blk, tex_req_idx}, 64'd0);
                end else begin
                    logic [15:0] e;
                    e = exp_req.pop_front();
                    check({tex_req_blk, tex_req_idx} == e, cur_label, "texel request address",
                          {48'd0, tex_req_blk, tex_req_idx}, {48'd0, e});
                end
                rsp_q.push_back(texel_of({tex_req_blk, tex_req_idx}));
                rsp_due.push_back(cyc + 2);
            end
            if (px_wr_en) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R6", "unexpected store", {6'd0, px_wr_addr, px_wr_color, px_wr_depth}, 64'd0);
                end else begin
                    logic [57:0] w;
                    w = exp_wr.pop_front();
                    check({px_wr_addr, px_wr_color, px_wr_depth} == w, cur_label, "store addr/color/depth",
                          {6'd0, px_wr_addr, px_wr_color, px_wr_depth}, {6'd0, w});
                end
            end
        end
    end

    task automatic run_prim(input string label, input int n,
                            input logic [11:0] s0, input logic [11:0] t0,
                            input logic [11:0] ds, input logic [11:0] dt,
                            input logic [15:0] z0, input logic [15:0] dz,
                            input logic [15:0] mask, input logic [31:0] modc,
                            input logic [9:0] base, input bit restart,
                            output int cycles);
        logic [11:0] s, t;
        logic [15:0] z;
        cur_label = label;
        s = s0; t = t0; z = z0;
        for (int i = 0; i < n; i++) begin
            logic [7:0]  si, ti, si1, ti1;
            logic [15:0] m[4];
            logic [31:0] tx[4];
            logic [31:0] col;
            logic [9:0]  a;
            si = s[11:4]; ti = t[11:4];
            si1 = si + 8'd1; ti1 = ti + 8'd1;
            m[0] = morton(si, ti) & mask;
            m[1] = morton(si1, ti) & mask;
            m[2] = morton(si, ti1) & mask;
            m[3] = morton(si1, ti1) & mask;
            for (int k = 0; k < 4; k++) begin
                exp_req.push_back(m[k]);
                tx[k] = texel_of(m[k]);
            end
            for (int c = 0; c < 4; c++) begin
                logic [7:0] tp, bt, mx;
                tp = blend(tx[0][c*8 +: 8], tx[1][c*8 +: 8], s[3:0]);
                bt = blend(tx[2][c*8 +: 8], tx[3][c*8 +: 8], s[3:0]);
                mx = blend(tp, bt, t[3:0]);
                col[c*8 +: 8] = modul(mx, modc[c*8 +: 8]);
            end
            a = base + 10'(i);
            if (z < zmodel[a]) begin
                exp_wr.push_back({a, col, z});
                zmodel[a] = z;
            end
            s = s + ds; t = t + dt; z = z + dz;
        end
        @(negedge clk);
        pix_count = 12'(n); s_start = s0; t_start = t0; s_step = ds; t_step = dt;
        z_start = z0; z_step = dz; tex_mask = mask; mod_color = modc; dst_base = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        if (restart) begin
            repeat (3) @(negedge clk);
            cycles += 3;
            pix_count = 12'd7; s_start = 12'h777; dst_base = 10'd900; z_start = 16'h0001;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cycles += 1;
        end
        while (!done && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
        check(done == 1'b1, "R9", "done reached", {63'd0, done}, 64'd1);
        check(busy == 1'b0, "R9", "busy low with done", {63'd0, busy}, 64'd0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done lasts one cycle", {63'd0, done}, 64'd0);
        check(exp_req.size() == 0 && exp_wr.size() == 0, "R8", "all requests and stores seen",
              64'(exp_req.size() + exp_wr.size()), 64'd0);
    endtask

    initial begin
        int cyc_n;
        int bad;
        rst_n = 1'b0; start = 1'b0; pix_count = '0;
        s_start = '0; t_start = '0; s_step = '0; t_step = '0;
        z_start = '0; z_step = '0; tex_mask = '0; mod_color = '0; dst_base = '0;
        for (int i = 0; i < 1024; i++) zmodel[i] = 16'h4000;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", {63'd0, busy}, 64'd0);
        check(done == 1'b0, "R1", "done in reset", {63'd0, done}, 64'd0);
        check(tex_req_valid == 1'b0 && px_wr_en == 1'b0, "R1", "no traffic in reset",
              {62'd0, tex_req_valid, px_wr_en}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && tex_req_valid == 1'b0, "R1", "idle after reset",
              {62'd0, busy, tex_req_valid}, 64'd0);

        // R2 R4 R7: full mask, identity modulation, all stores pass
        run_prim("R2 R4 R7", 8, 12'h035, 12'h0A2, 12'h013, 12'h008, 16'h1000, 16'h0100,
                 16'hFFFF, 32'hFFFF_FFFF, 10'd0, 1'b0, cyc_n);

        // R3 R5 R8: wrap of S+1 at 255, narrow mask, modulation, stalled port
        stall_mode = 1'b1;
        run_prim("R3 R5 R8", 10, 12'hFD3, 12'h1F7, 12'h00B, 12'h0F1, 16'h2000, 16'hFF00,
                 16'h00FF, 32'h80_40_C0_FF, 10'd100, 1'b0, cyc_n);
        stall_mode = 1'b0;

        // R6: first pixel equal depth (not stored), later pixels nearer
        run_prim("R6", 8, 12'h000, 12'h034, 12'h017, 12'h005, 16'h1000, 16'h0080,
                 16'h0FFF, 32'hFFFF_FFFF, 10'd0, 1'b0, cyc_n);

        // R10: a second start while busy is ignored
        run_prim("R10", 12, 12'h120, 12'h3C9, 12'h021, 12'hFF3, 16'h0500, 16'h0011,
                 16'hFFFF, 32'h10_FF_7F_01, 10'd300, 1'b1, cyc_n);
        repeat (10) @(negedge clk);
        check(busy == 1'b0 && exp_req.size() == 0, "R10", "no run after ignored start",
              {63'd0, busy}, 64'd0);

        // R9: zero pixel count
        run_prim("R9", 0, 12'h000, 12'h000, 12'h010, 12'h010, 16'h0001, 16'h0001,
                 16'hFFFF, 32'hFFFF_FFFF, 10'd600, 1'b0, cyc_n);
        check(cyc_n <= 3, "R9", "count zero latency", 64'(cyc_n), 64'd3);

        // R11: overlap keeps four cycles per pixel
        run_prim("R11", 16, 12'h2A9, 12'h051, 12'h00C, 12'h019, 16'h0100, 16'h0003,
                 16'hFFFF, 32'hC0_C0_C0_C0, 10'd500, 1'b0, cyc_n);
        check(cyc_n <= 4 * 16 + 12, "R11", "pipelined run length", 64'(cyc_n), 64'(4 * 16 + 12));

        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 1024; i++) if (zmem[i] != zmodel[i]) bad++;
        check(bad == 0, "R6 R7", "depth array mismatches", 64'(bad), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule